// File: doc/BRIEF.md
# Position Latch with Coherent Byte Reads

This block keeps a 16-bit up/down position count and presents it to an 8-bit processor bus through a holding latch. A quadrature decoder upstream supplies one-cycle count-up and count-down strobes. The count register always follows those strobes. While no read is in progress, the holding latch copies the count on every clock.

A processor reads the position as two byte accesses: high byte first, then low byte. The high-byte access freezes the holding latch, so the low byte read afterwards belongs to the same sample even when the count moves in between. The freeze lifts only after the low-byte access, followed by a clock edge with output-enable released. The latch then resumes refreshing on the next edge.

A one-cycle wrap pulse with a direction flag lets an external counter extend the position beyond 16 bits. The bus is modelled as a data vector plus a drive-enable, not as a tri-state net.

Top module: `posn_byte_reader`

## Requirements
- R1: The count increments by one on a clock edge where only `cnt_up` is high, and decrements by one where only `cnt_dn` is high, both modulo 2^16.
- R2: While no freeze is active and the current access is not a high-byte access, each clock edge loads the holding latch with the count value present before that edge.
- R3: A clock edge with `oe_n` low and `byte_sel` low (high-byte access), seen while not frozen, sets the freeze and does not load the latch at that edge. During that access the bus carries latch bits 15:8.
- R4: With `oe_n` low and `byte_sel` high, the bus carries latch bits 7:0 and `bus_drive` is 1.
- R5: With `oe_n` high, `bus_drive` is 0 and `bus_data` is zero.
- R6: The freeze clears only after two conditions, in order: a clock edge with `oe_n` low and `byte_sel` high, then a later clock edge with `oe_n` high. Raising `oe_n` before the low-byte access does not clear it. Latch loading resumes on the edge after the freeze clears.
- R7: A low-byte access made while not frozen does not set the freeze: the latch keeps refreshing each edge during that access.
- R8: `wrap_pulse` is high for the one cycle after an edge where the count moves from FFFF to 0000 (with `wrap_up` = 1) or from 0000 to FFFF (with `wrap_up` = 0). Otherwise both are 0.
- R9: The count keeps following the strobes while the freeze is active.
- R10: While `rst_n` is sampled low at a clock edge, the count and latch clear to zero, the freeze is released and `wrap_pulse` is 0.
- R11: When both strobes are high, or both are low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_up | input | 1 | Count-up strobe from the edge decoder |
| cnt_dn | input | 1 | Count-down strobe from the edge decoder |
| byte_sel | input | 1 | 0 selects the high byte, 1 selects the low byte |
| oe_n | input | 1 | Active-low output enable for the bus access |
| bus_data | output | 8 | Selected latch byte; zero when not enabled |
| bus_drive | output | 1 | High when the bus should be driven |
| wrap_pulse | output | 1 | One-cycle pulse on a 16-bit count wrap |
| wrap_up | output | 1 | Wrap direction; 1 for an upward wrap, valid with the pulse |

## Verification
A stuck or wrongly sequenced freeze state appears at the ports on the next byte access. The low byte read after a high byte then comes from a newer sample, or the value stays frozen after the release edge. The reference model flags this on the first clock where the bus differs. A wrong count shows up on the bus one edge later, through the latch. A missing or misdirected wrap appears in the cycle right after the wrapping edge. Directed reads are placed around the freeze edges: a stream of counting during the read, a premature `oe_n` release, and a low-only read. Each wrong transition therefore produces a byte that a correct design could not show.

// File: rtl/qlr_pkg.sv
package qlr_pkg;

    // Read-freeze sequencing: idle, frozen after high byte, low byte seen
    typedef enum logic [1:0] {
        FRZ_IDLE = 2'd0,
        FRZ_HELD = 2'd1,
        FRZ_HALF = 2'd2
    } frz_state_e;

endpackage

// File: rtl/qlr_counter.sv
module qlr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic         wrap_up_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wrap;
        logic         wrap_up;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d         = ctr_q;
        ctr_d.wrap    = 1'b0;
        ctr_d.wrap_up = 1'b0;
        if (step_up && !step_dn) begin
            ctr_d.cnt = ctr_q.cnt + W'(1);
            if (ctr_q.cnt == CNT_MAX) begin
                ctr_d.wrap    = 1'b1;
                ctr_d.wrap_up = 1'b1;
            end
        end else if (step_dn && !step_up) begin
            ctr_d.cnt = ctr_q.cnt - W'(1);
            if (ctr_q.cnt == '0) begin
                ctr_d.wrap = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o     = ctr_q.cnt;
    assign wrap_o    = ctr_q.wrap;
    assign wrap_up_o = ctr_q.wrap_up;

    // R8
    wrap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.wrap_up |-> ctr_q.wrap);

    // R8
    wrap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.wrap |-> (ctr_q.cnt == (ctr_q.wrap_up ? '0 : CNT_MAX)));

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn) |=> (ctr_q.cnt == $past(ctr_q.cnt) + W'(1)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up == step_dn) |=> $stable(ctr_q.cnt));

endmodule

// File: rtl/qlr_freeze_ctl.sv
module qlr_freeze_ctl
    import qlr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic byte_sel,
    output logic frozen_o,
    output logic load_o
);

    typedef struct packed {
        frz_state_e st;
    } frz_t;

    frz_t frz_d, frz_q;

    logic hi_access, lo_access;

    always_comb begin
        hi_access = !oe_n && !byte_sel;
        lo_access = !oe_n && byte_sel;
        frz_d     = frz_q;
        unique case (frz_q.st)
            FRZ_IDLE: if (hi_access) frz_d.st = FRZ_HELD;
            FRZ_HELD: if (lo_access) frz_d.st = FRZ_HALF;
            FRZ_HALF: if (oe_n)      frz_d.st = FRZ_IDLE;
            default:                 frz_d.st = FRZ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q.st <= FRZ_IDLE;
        end else begin
            frz_q <= frz_d;
        end
    end

    assign frozen_o = (frz_q.st != FRZ_IDLE);
    assign load_o   = (frz_q.st == FRZ_IDLE) && !hi_access;

    // R3
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen_o && !oe_n && !byte_sel) |=> frozen_o);

    // R7
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen_o && (oe_n || byte_sel)) |=> !frozen_o);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frozen_o) |-> ($past(oe_n) && $past(frz_q.st) == FRZ_HALF));

    // R6
    held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q.st == FRZ_HELD) |=> frozen_o);

endmodule

// File: rtl/qlr_byte_mux.sv
module qlr_byte_mux #(
    parameter int BUS_W = 8,
    parameter int LANES = 2
) (
    input  logic [BUS_W*LANES-1:0] word_i,
    input  logic                   byte_sel,
    input  logic                   oe_n,
    output logic [BUS_W-1:0]       data_o,
    output logic                   drive_o
);

    localparam int HI_LANE = LANES - 1;

    logic [BUS_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BUS_W +: BUS_W];
    end

    always_comb begin
        drive_o = !oe_n;
        data_o  = '0;
        if (!oe_n) begin
            data_o = byte_sel ? lane[0] : lane[HI_LANE];
        end
    end

endmodule

// File: rtl/posn_byte_reader.sv
module posn_byte_reader #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    input  logic             byte_sel,
    input  logic             oe_n,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_drive,
    output logic             wrap_pulse,
    output logic             wrap_up
);

    localparam int LANES = 2;
    localparam int CNT_W = BUS_W * LANES;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } latch_t;

    latch_t           latch_d, latch_q;
    logic [CNT_W-1:0] cnt;
    logic             frozen, load;

    qlr_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (cnt_up),
        .step_dn   (cnt_dn),
        .cnt_o     (cnt),
        .wrap_o    (wrap_pulse),
        .wrap_up_o (wrap_up)
    );

    qlr_freeze_ctl u_freeze (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .byte_sel (byte_sel),
        .frozen_o (frozen),
        .load_o   (load)
    );

    always_comb begin
        latch_d = latch_q;
        if (load) begin
            latch_d.pos = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    qlr_byte_mux #(.BUS_W(BUS_W), .LANES(LANES)) u_mux (
        .word_i   (latch_q.pos),
        .byte_sel (byte_sel),
        .oe_n     (oe_n),
        .data_o   (bus_data),
        .drive_o  (bus_drive)
    );

    // R2
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(latch_q.pos));

    // R2
    refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch_q.pos == $past(cnt)));

    // R5
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!bus_drive && bus_data == '0));

endmodule

// File: tb/posn_byte_reader_tb.sv
module posn_byte_reader_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_up = 1'b0, cnt_dn = 1'b0, byte_sel = 1'b1, oe_n = 1'b1;
    logic [7:0] bus_data;
    logic       bus_drive, wrap_pulse, wrap_up;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_cnt = 0, m_latch = 0, m_st = 0;
    bit m_wrap = 1'b0, m_wup = 1'b0;

    always #5 clk = ~clk;

    posn_byte_reader dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .byte_sel(byte_sel), .oe_n(oe_n), .bus_data(bus_data),
        .bus_drive(bus_drive), .wrap_pulse(wrap_pulse), .wrap_up(wrap_up)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_st = 0; m_wrap = 0; m_wup = 0;
        end else begin
            if (m_st == 0 && !(!oe_n && !byte_sel)) m_latch = m_cnt;
            m_wrap = 0; m_wup = 0;
            if (cnt_up && !cnt_dn) begin
                if (m_cnt == 16'hFFFF) begin m_wrap = 1; m_wup = 1; end
                m_cnt = (m_cnt + 1) & 16'hFFFF;
            end else if (cnt_dn && !cnt_up) begin
                if (m_cnt == 0) m_wrap = 1;
                m_cnt = (m_cnt + 16'hFFFF) & 16'hFFFF;
            end
            case (m_st)
                0: if (!oe_n && !byte_sel) m_st = 1;
                1: if (!oe_n && byte_sel)  m_st = 2;
                default: if (oe_n)         m_st = 0;
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5", bus_drive, !oe_n);
            if (oe_n)          chk("R5", bus_data, 0);
            else if (byte_sel) chk("R2 R4", bus_data, m_latch & 8'hFF);
            else               chk("R2 R3", bus_data, (m_latch >> 8) & 8'hFF);
            chk("R8", wrap_pulse, m_wrap);
            chk("R8", wrap_up, m_wup);
        end
    end

    task automatic step(input logic up, input logic dn, input logic sel, input logic oe);
        @(negedge clk);
        #1;
        cnt_up = up; cnt_dn = dn; byte_sel = sel; oe_n = oe;
    endtask

    initial begin
        // R10: reset with counting and a low-byte read requested
        cnt_up = 1'b1; byte_sel = 1'b1; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", bus_data, 0);
        chk("R10", wrap_pulse, 0);
        #1;
        rst_n = 1'b1; cnt_up = 1'b0; oe_n = 1'b1;

        // R1: five up-steps
        repeat (5) step(1, 0, 1, 1);
        repeat (2) step(0, 0, 1, 1);
        step(0, 0, 1, 0); #2;
        chk("R1", bus_data, 8'h05);

        // R11: both strobes hold
        repeat (3) step(1, 1, 1, 1);
        repeat (2) step(0, 0, 1, 1);
        step(0, 0, 1, 0); #2;
        chk("R11", bus_data, 8'h05);

        // R1: down-steps
        repeat (2) step(0, 1, 1, 1);
        repeat (2) step(0, 0, 1, 1);
        step(0, 0, 1, 0); #2;
        chk("R1", bus_data, 8'h03);

        // climb to 0x00FE
        repeat (251) step(1, 0, 1, 1);
        repeat (2) step(0, 0, 1, 1);

        // R3: high-byte read freezes while counting continues
        step(1, 0, 0, 0); #2;
        chk("R3", bus_data, 8'h00);
        chk("R3", bus_drive, 1);
        repeat (3) step(1, 0, 0, 0);
        // R6: oe_n high before the low byte does not release
        repeat (2) step(1, 0, 1, 1);
        step(1, 0, 1, 0); #2;
        chk("R6 R3", bus_data, 8'hFE);
        // release edge
        step(1, 0, 1, 1); #2;
        chk("R5", bus_drive, 0);
        step(0, 0, 1, 1);
        // R9: counting during freeze was kept (0x0106)
        step(0, 0, 1, 0); #2;
        chk("R9 R6", bus_data, 8'h06);
        step(0, 0, 0, 0); #2;
        chk("R9", bus_data, 8'h01);
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);

        // R7: low-only reads keep refreshing
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        step(1, 0, 1, 0); #2;
        chk("R7", bus_data, 8'h07);
        step(1, 0, 1, 0); #2;
        chk("R7", bus_data, 8'h08);
        step(0, 0, 1, 1);

        // R8: wraps from a fresh reset
        @(negedge clk); #1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        step(0, 1, 1, 1);
        @(posedge clk); #1;
        chk("R8", wrap_pulse, 1);
        chk("R8", wrap_up, 0);
        step(1, 0, 1, 1);
        @(posedge clk); #1;
        chk("R8", wrap_pulse, 1);
        chk("R8", wrap_up, 1);
        step(0, 0, 1, 1);
        @(posedge clk); #1;
        chk("R8", wrap_pulse, 0);
        repeat (3) step(0, 0, 1, 1);

        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule